// File: doc/BRIEF.md
# Framebuffer window fetch address generator

This block walks one overlay window of a linear framebuffer and emits the burst read requests a memory fetch engine needs to bring the window's pixels on chip. The window may be narrower than the framebuffer. Each line is fetched as a run of whole 32-bit words of a given byte width. A separate skip distance is then added to jump over the part of the framebuffer line that lies outside the window. The fetch ends once the next line would start at or beyond a configured end address.

Software sets the start address, end address, line width in bytes, skip distance in bytes and pixel depth, then pulses `frame_start`. On that pulse the block captures the configuration and starts issuing requests. Each request carries a word-aligned byte address and a length in 32-bit words. The pixel depth selects the longest burst used.

Requests leave on a valid/ready channel. The block holds `req_valid` with a stable address and length until `req_ready` is high on a clock edge. It never withdraws a request, except when `frame_start` aborts the frame. While `req_ready` stays low the block waits and loses no request.

Top module: `fb_window_fetch`

## Requirements
- R1: After reset `req_valid` is low, and it stays low until the first `frame_start` pulse.
- R2: The depth input gives bits per pixel as a binary number. The longest burst is 4 words for depth 1, 8 words for depths 2, 4 and 8, and 16 words for depths 16, 24 and 32. Any other depth value, including 0, 7 and 12, uses 16 words.
- R3: Every request address has its two low bits at zero. The two low bits of the start address, end address, line width and skip distance are ignored. The line width in words is the byte width divided by four, rounded down.
- R4: A line is fetched as maximum-length bursts at increasing addresses, each burst starting right after the previous one. The last burst of the line is shortened to the words that remain, so no burst crosses the end of a line.
- R5: The first burst of the next line starts at the byte after the previous line's last word plus the skip distance.
- R6: `req_valid` falls after the last burst of the line whose successor would start at or above the end address. No request is made at all if the start address is not below the end address or the line width is under one word.
- R7: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_addr` and `req_len` keep their values into the next cycle, unless `frame_start` is high.
- R8: `frame_start` captures all configuration inputs and restarts at the start address. It abandons any frame in progress. A request presented in the same cycle as `frame_start` is not consumed. Configuration changes after the pulse have no effect until the next pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | One-cycle pulse: capture configuration, restart |
| cfg_start_addr | input | ADDR_W | Byte address of the window's first pixel |
| cfg_end_addr | input | ADDR_W | Byte address at or past which fetching stops |
| cfg_page_bytes | input | PW_W | Visible bytes per window line |
| cfg_skip_bytes | input | OFS_W | Bytes skipped after each line |
| cfg_depth | input | BPP_W | Bits per pixel, binary |
| req_valid | output | 1 | Burst request present |
| req_ready | input | 1 | Consumer accepts the request on this edge |
| req_addr | output | ADDR_W | Word-aligned byte address of the burst |
| req_len | output | LEN_W | Burst length in 32-bit words |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, 14-bit line width and skip fields, a 6-bit depth code and a 5-bit length. These widths allow lines shorter than one burst, lines that are an exact multiple of the burst, and lines that leave a short tail. All three burst classes are reachable, and depth codes outside the listed set exercise the fallback. Small windows keep every frame to a few dozen bursts. This leaves room for several ready patterns, a held request and a frame aborted part way through.

// File: rtl/fbwf_pkg.sv
package fbwf_pkg;
  // Burst size classes chosen from pixel depth.
  typedef enum logic [1:0] {
    CLS_BURST4  = 2'd0,
    CLS_BURST8  = 2'd1,
    CLS_BURST16 = 2'd2
  } burst_cls_t;

  // Words per burst for each class.
  function automatic int unsigned cls_words(input burst_cls_t c);
    case (c)
      CLS_BURST4: return 4;
      CLS_BURST8: return 8;
      default:    return 16;
    endcase
  endfunction
endpackage

// File: rtl/fbwf_burst_sel.sv
module fbwf_burst_sel
  import fbwf_pkg::*;
#(
  parameter int unsigned BPP_W = 6,
  parameter int unsigned LEN_W = 5
) (
  input  logic [BPP_W-1:0] depth,
  output logic [LEN_W-1:0] burst_words
);
  burst_cls_t cls;

  // Deep pixels and unknown codes share the longest burst.
  always_comb begin
    cls = CLS_BURST16;
    if (depth == BPP_W'(1))
      cls = CLS_BURST4;
    else if (depth == BPP_W'(2) || depth == BPP_W'(4) || depth == BPP_W'(8))
      cls = CLS_BURST8;
  end

  assign burst_words = LEN_W'(cls_words(cls));
endmodule

// File: rtl/fbwf_line_ctr.sv
module fbwf_line_ctr #(
  parameter int unsigned WORDS_W = 12,
  parameter int unsigned LEN_W   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [WORDS_W-1:0] page_words,
  input  logic [LEN_W-1:0]   burst_cap,
  input  logic               advance,
  output logic [LEN_W-1:0]   len,
  output logic               line_last
);
  logic [WORDS_W-1:0] page_q;
  logic [WORDS_W-1:0] left_q;
  logic [LEN_W-1:0]   cap_q;
  logic [WORDS_W-1:0] cap_ext;

  assign cap_ext   = WORDS_W'(cap_q);
  assign line_last = (left_q <= cap_ext);
  assign len       = line_last ? LEN_W'(left_q) : cap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      left_q <= '0;
      cap_q  <= '0;
    end else if (load) begin
      page_q <= page_words;
      left_q <= page_words;
      cap_q  <= burst_cap;
    end else if (advance) begin
      if (line_last) left_q <= page_q;
      else           left_q <= left_q - cap_ext;
    end
  end
endmodule

// File: rtl/fbwf_addr_gen.sv
module fbwf_addr_gen #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFS_W  = 14,
  parameter int unsigned LEN_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [ADDR_W-1:0] end_addr,
  input  logic [OFS_W-1:0]  skip_bytes,
  input  logic              page_nz,
  input  logic              advance,
  input  logic [LEN_W-1:0]  len,
  input  logic              line_last,
  output logic [ADDR_W-1:0] addr,
  output logic              active
);
  localparam logic [ADDR_W-1:0] AMASK = ~ADDR_W'(3);
  localparam logic [OFS_W-1:0]  OMASK = ~OFS_W'(3);

  logic [ADDR_W-1:0] addr_q, end_q, step, line_next, start_al, end_al;
  logic [OFS_W-1:0]  skip_q;
  logic              active_q;

  assign start_al  = start_addr & AMASK;
  assign end_al    = end_addr & AMASK;
  assign step      = ADDR_W'(len) << 2;
  assign line_next = addr_q + step + ADDR_W'(skip_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      end_q    <= '0;
      skip_q   <= '0;
      active_q <= 1'b0;
    end else if (load) begin
      addr_q   <= start_al;
      end_q    <= end_al;
      skip_q   <= skip_bytes & OMASK;
      active_q <= page_nz && (start_al < end_al);
    end else if (advance) begin
      if (line_last) begin
        addr_q <= line_next;
        if (line_next >= end_q) active_q <= 1'b0;
      end else begin
        addr_q <= addr_q + step;
      end
    end
  end

  assign addr   = addr_q;
  assign active = active_q;
endmodule

// File: rtl/fb_window_fetch.sv
module fb_window_fetch #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned PW_W   = 14,
  parameter int unsigned OFS_W  = 14,
  parameter int unsigned BPP_W  = 6,
  parameter int unsigned LEN_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic [ADDR_W-1:0] cfg_start_addr,
  input  logic [ADDR_W-1:0] cfg_end_addr,
  input  logic [PW_W-1:0]   cfg_page_bytes,
  input  logic [OFS_W-1:0]  cfg_skip_bytes,
  input  logic [BPP_W-1:0]  cfg_depth,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic [LEN_W-1:0]  req_len
);
  localparam int unsigned WORDS_W = PW_W - 2;

  logic [WORDS_W-1:0] page_words;
  logic [LEN_W-1:0]   cap_words;
  logic [LEN_W-1:0]   cur_len;
  logic               line_last;
  logic               active;
  logic               advance;

  assign page_words = cfg_page_bytes[PW_W-1:2];
  // A restart wins over a handshake in the same cycle.
  assign advance    = active & req_ready & ~frame_start;

  fbwf_burst_sel #(.BPP_W(BPP_W), .LEN_W(LEN_W)) u_burst (
    .depth       (cfg_depth),
    .burst_words (cap_words)
  );

  fbwf_line_ctr #(.WORDS_W(WORDS_W), .LEN_W(LEN_W)) u_line (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (frame_start),
    .page_words (page_words),
    .burst_cap  (cap_words),
    .advance    (advance),
    .len        (cur_len),
    .line_last  (line_last)
  );

  fbwf_addr_gen #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .LEN_W(LEN_W)) u_addr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (frame_start),
    .start_addr (cfg_start_addr),
    .end_addr   (cfg_end_addr),
    .skip_bytes (cfg_skip_bytes),
    .page_nz    (page_words != '0),
    .advance    (advance),
    .len        (cur_len),
    .line_last  (line_last),
    .addr       (req_addr),
    .active     (active)
  );

  assign req_valid = active;
  assign req_len   = cur_len;
endmodule

// File: rtl/fbwf_chk.sv
module fbwf_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LEN_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_start,
  input logic [ADDR_W-1:0] cfg_start_addr,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic [LEN_W-1:0]  req_len
);
  logic seen_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           seen_start <= 1'b0;
    else if (frame_start) seen_start <= 1'b1;
  end

  assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_start |-> !req_valid);

  assert_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_addr[1:0] == 2'b00));

  assert_len_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_len != '0 && req_len <= LEN_W'(16)));

  assert_forward_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !frame_start) |=> (!req_valid || req_addr > $past(req_addr)));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !frame_start) |=> (req_valid && $stable(req_addr) && $stable(req_len)));

  assert_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (!req_valid || req_addr == ($past(cfg_start_addr) & ~ADDR_W'(3))));
endmodule

bind fb_window_fetch fbwf_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_fbwf_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .frame_start    (frame_start),
  .cfg_start_addr (cfg_start_addr),
  .req_valid      (req_valid),
  .req_ready      (req_ready),
  .req_addr       (req_addr),
  .req_len        (req_len)
);

// File: tb/test_fb_window_fetch.sv
module test_fb_window_fetch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_start = 1'b0;
  logic [31:0] cfg_start_addr = '0;
  logic [31:0] cfg_end_addr = '0;
  logic [13:0] cfg_page_bytes = '0;
  logic [13:0] cfg_skip_bytes = '0;
  logic [5:0]  cfg_depth = '0;
  logic        req_valid;
  logic        req_ready = 1'b0;
  logic [31:0] req_addr;
  logic [4:0]  req_len;

  typedef struct { logic [31:0] a; logic [4:0] l; } beat_t;
  beat_t exp_q[$];

  int checks = 0;
  int failures = 0;
  int ready_mode = 0;
  int cyc = 0;
  logic [7:0] lfsr = 8'hA5;
  bit hold_pend = 0;
  logic [31:0] h_addr;
  logic [4:0]  h_len;

  always #5 clk = ~clk;

  fb_window_fetch i_fb_window_fetch (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .cfg_start_addr(cfg_start_addr), .cfg_end_addr(cfg_end_addr),
    .cfg_page_bytes(cfg_page_bytes), .cfg_skip_bytes(cfg_skip_bytes),
    .cfg_depth(cfg_depth), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len)
  );

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // Consumer ready patterns.
  initial begin
    forever begin
      @(posedge clk); #1;
      cyc++;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      case (ready_mode)
        0: req_ready = 1'b1;
        1: req_ready = cyc[0];
        2: req_ready = lfsr[0];
        default: req_ready = (cyc % 6 == 0);
      endcase
    end
  end

  // Monitor: scoreboard and hold checks.
  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_pend)
        check(req_valid && req_addr == h_addr && req_len == h_len,
              "R7", "held request changed", {req_valid, req_addr}, {1'b1, h_addr});
      hold_pend = req_valid && !req_ready && !frame_start;
      h_addr = req_addr;
      h_len = req_len;
      if (req_valid && req_ready && !frame_start) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R6", "unexpected burst addr", req_addr, 0);
        end else begin
          beat_t e;
          e = exp_q.pop_front();
          check(req_addr == e.a, "R4/R5", "burst address", req_addr, e.a);
          check(req_len == e.l, "R2/R4", "burst length", req_len, e.l);
        end
      end
    end else begin
      hold_pend = 0;
    end
  end

  // Watchdog.
  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "WDOG", "watchdog expired", 0, 1);
    finish_run();
  end

  function automatic int cap_of(int d);
    if (d == 1) return 4;
    if (d == 2 || d == 4 || d == 8) return 8;
    return 16;
  endfunction

  task automatic push_model(logic [31:0] s, logic [31:0] e, int p, int o, int d);
    int cap;
    int words;
    int skip;
    logic [31:0] a;
    logic [31:0] ea;
    cap = cap_of(d);
    words = (p & 16'h3FFF) >> 2;
    skip = o & 16'h3FFC;
    a = s & ~32'd3;
    ea = e & ~32'd3;
    if (words == 0 || a >= ea) return;
    while (1) begin
      int left;
      left = words;
      while (left > 0) begin
        int l;
        beat_t b;
        l = (left < cap) ? left : cap;
        b.a = a;
        b.l = 5'(l);
        exp_q.push_back(b);
        a += 32'(l * 4);
        left -= l;
      end
      a += 32'(skip);
      if (a >= ea) break;
    end
  endtask

  // Driver: pulse frame_start, load the expectations, then scramble config (R8).
  task automatic start_frame(logic [31:0] s, logic [31:0] e, int p, int o, int d);
    @(posedge clk); #1;
    cfg_start_addr = s;
    cfg_end_addr = e;
    cfg_page_bytes = 14'(p);
    cfg_skip_bytes = 14'(o);
    cfg_depth = 6'(d);
    frame_start = 1'b1;
    exp_q.delete();
    hold_pend = 0;
    push_model(s, e, p, o, d);
    @(posedge clk); #1;
    frame_start = 1'b0;
    cfg_start_addr = 32'h00F0_0000;
    cfg_end_addr = 32'h00F0_0004;
    cfg_page_bytes = 14'h4;
    cfg_skip_bytes = 14'h100;
    cfg_depth = 6'd1;
  endtask

  task automatic wait_done(string what);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (exp_q.size() == 0 && !req_valid) break;
    end
    check(exp_q.size() == 0 && !req_valid, "R6", what, exp_q.size(), 0);
    repeat (4) @(negedge clk);
    check(!req_valid, "R6", {what, " stays idle"}, req_valid, 0);
  endtask

  initial begin
    int depths[8] = '{1, 2, 4, 8, 24, 7, 0, 12};
    repeat (3) @(negedge clk);
    check(req_valid == 1'b0, "R1", "valid in reset", req_valid, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(req_valid == 1'b0, "R1", "valid before first frame", req_valid, 0);

    // R4/R5: lines that are an exact burst multiple.
    ready_mode = 0;
    start_frame(32'h1000, 32'h1000 + 3 * 96, 64, 32, 32);
    wait_done("R4 full bursts frame end");

    // R4: short tail burst, alternating ready.
    ready_mode = 1;
    start_frame(32'h2000, 32'h2000 + 2 * 120, 100, 20, 16);
    wait_done("R4 tail burst frame end");

    // R2: every burst class and fallback codes.
    ready_mode = 2;
    foreach (depths[k]) begin
      start_frame(32'h3000, 32'h3000 + 2 * 96, 80, 16, depths[k]);
      wait_done($sformatf("R2 depth %0d frame end", depths[k]));
    end

    // R3: unaligned low bits ignored.
    ready_mode = 0;
    start_frame(32'h4003, 32'h4003 + 2 * 72, 32'h43, 32'h0B, 32);
    wait_done("R3 unaligned frame end");

    // R7: long stalls.
    ready_mode = 3;
    start_frame(32'h5000, 32'h5000 + 2 * 60, 52, 8, 8);
    wait_done("R7 stalled frame end");

    // R6: empty frames.
    ready_mode = 0;
    start_frame(32'h6000, 32'h6000, 64, 0, 32);
    wait_done("R6 start equals end");
    start_frame(32'h6000, 32'h7000, 3, 0, 32);
    wait_done("R6 line under one word");

    // R8: abort part way and restart with new settings.
    ready_mode = 2;
    start_frame(32'h8000, 32'h8000 + 8 * 256, 200, 56, 16);
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (exp_q.size() < 20) break;
    end
    check(exp_q.size() > 0, "R8", "abort happens mid frame", exp_q.size(), 1);
    start_frame(32'h9000, 32'h9000 + 3 * 40, 24, 16, 4);
    wait_done("R8 restarted frame end");

    finish_run();
  end
endmodule